// File: doc/BRIEF.md
# Four-Way Write-Back Cache Tag Directory

This block holds the metadata of a 4-way set-associative write-back data cache and runs the lookup for each request. A request is a 32-bit byte address and a load/store flag. The block ignores the low 5 bits, because blocks are 32 bytes. The next 11 bits pick one of 2048 sets, and the upper 16 bits are compared as a tag against all four ways of that set. The result gives hit or miss and the way that was used. The data array and the memory side are not part of this block; it only produces metadata and control outputs.

Each way entry holds a tag, two valid bits, one modified bit and one recently-used bit. On a miss, a victim way is chosen and the new tag is installed in that way in the same step. If the victim holds modified data, a write-back request is raised together with the block address of the victim. After reset, a sweep clears every entry and the block reports not-ready until the sweep is done. Requests can arrive every cycle. Two requests in a row to the same set see each other's updates.

Top module: `wb_tag_directory`

## Requirements
- R1: Address bits [4:0] do not affect the lookup. Bits [15:5] select the set and bits [31:16] form the tag. Two addresses in the same 32-byte block give the same result. The same tag in a different set is a separate entry.
- R2: After reset, `ready` stays low for exactly 2048 cycles while all entries are cleared to invalid and clean, and `resp_valid` stays low. Once `ready` rises, it stays high until the next reset.
- R3: A request is accepted in a cycle where `req_valid` and `ready` are both high. Its result appears on the response outputs, with `resp_valid` high for one cycle, two clock edges after the edge that accepted it. When no request is accepted, `resp_valid` is low two edges later.
- R4: A request hits when one way in the set has both valid bits set and a tag equal to the request tag. `resp_hit` is then 1 and `resp_way` gives that way (0 to 3).
- R5: On a miss, the victim is the lowest-numbered way that is not valid. If all four ways are valid, the victim is the lowest-numbered way whose recently-used bit is clear. `resp_way` reports the victim, which then holds the new tag and is valid.
- R6: On every hit or fill, the recently-used bit of the way that was used is set. If this would leave all four bits in the set, the other three bits are cleared.
- R7: A store hit sets the modified bit of the way that hit. A load miss installs the line clean. A store miss installs the line modified.
- R8: `wb_req` is 1 only for a miss whose victim was valid and modified. In that case `wb_addr` = {victim tag, set, 5'b0}. A hit never raises `wb_req`.
- R9: A request that follows the previous one in the very next cycle, to the same set, sees that request's tag, modified and recently-used updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| ready | output | 1 | High once the post-reset clear is done |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | 2 | Hit way, or victim way on a miss |
| wb_req | output | 1 | Victim must be written back |
| wb_addr | output | 32 | Block address of the victim |

## Verification
Two things can happen in the same cycle. The entry update of one request is written into the directory memory at the same clock edge where the next request reads that set. If the memory returned the old contents, the second request would miss a tag that was just installed, or it would lose a modified bit. To provoke this, the bench sends back-to-back requests to the same set: a miss followed at once by a hit to the same block, and random streams drawn from a small pool of sets and tags. Every response is compared with a bench model that applies the requests strictly in order.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } tagdir_op_e;

  // Flag bits sitting below the tag in every way word
  localparam int unsigned FLAG_BITS = 4;
  localparam int unsigned F_REF     = 0;
  localparam int unsigned F_DIRTY   = 1;
  localparam int unsigned F_VLO     = 2;
  localparam int unsigned F_VHI     = 3;

endpackage

// File: rtl/tdir_way_ram.sv
module tdir_way_ram #(
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read; read-during-write returns old word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
    rd_word <= mem[rd_idx];
  end
endmodule

// File: rtl/tdir_init_sweep.sv
module tdir_init_sweep #(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/tdir_victim_pick.sv
module tdir_victim_pick #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAYS-1:0]  ref_vec,
  output logic [WAY_W-1:0] victim
);
  logic found;

  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !ref_vec[i]) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdir_ref_update.sv
module tdir_ref_update #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]  ref_in,
  input  logic [WAY_W-1:0] used_way,
  output logic [WAYS-1:0]  ref_out
);
  logic [WAYS-1:0] used_oh;
  logic [WAYS-1:0] merged;

  always_comb begin
    used_oh = WAYS'(1) << used_way;
    merged  = ref_in | used_oh;
    ref_out = (&merged) ? used_oh : merged;
  end
endmodule

// File: rtl/wb_tag_directory.sv
module wb_tag_directory
  import tagdir_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 5,
  parameter int unsigned SET_W    = 11,
  parameter int unsigned WAYS     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_store,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     ready,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [$clog2(WAYS)-1:0]  resp_way,
  output logic                     wb_req,
  output logic [ADDR_W-1:0]        wb_addr
);
  localparam int unsigned TAG_W  = ADDR_W - SET_W - OFFSET_W;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned WORD_W = TAG_W + FLAG_BITS;

  // Request fields
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic             offset_unused;

  assign req_set       = req_addr[OFFSET_W +: SET_W];
  assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign offset_unused = ^req_addr[OFFSET_W-1:0];

  // Post-reset clear
  logic             sweep_active;
  logic [SET_W-1:0] sweep_idx;

  tdir_init_sweep #(.IDX_W(SET_W)) u_sweep (
    .clk    (clk),
    .rst    (rst),
    .active (sweep_active),
    .idx    (sweep_idx)
  );

  assign ready = !sweep_active;

  logic accept;
  assign accept = req_valid && !sweep_active;

  // Lookup stage registers
  logic             s1_vld;
  tagdir_op_e       s1_op;
  logic [SET_W-1:0] s1_set;
  logic [TAG_W-1:0] s1_tag;
  logic             s1_fwd;

  logic [WORD_W-1:0] rd_word  [WAYS];
  logic [WORD_W-1:0] fwd_word [WAYS];
  logic [WORD_W-1:0] cur_word [WAYS];
  logic [WORD_W-1:0] new_word [WAYS];

  logic [WAYS-1:0] valid_vec;
  logic [WAYS-1:0] ref_vec;
  logic [WAYS-1:0] hit_vec;

  // One memory per way, plus per-way decode
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic              wr_en;
    logic [SET_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;

    assign wr_en   = sweep_active || s1_vld;
    assign wr_idx  = sweep_active ? sweep_idx : s1_set;
    assign wr_word = sweep_active ? '0 : new_word[g];

    tdir_way_ram #(.IDX_W(SET_W), .WORD_W(WORD_W)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_word (wr_word),
      .rd_idx  (req_set),
      .rd_word (rd_word[g])
    );

    assign cur_word[g]  = s1_fwd ? fwd_word[g] : rd_word[g];
    assign valid_vec[g] = cur_word[g][F_VHI] && cur_word[g][F_VLO];
    assign ref_vec[g]   = cur_word[g][F_REF];
    assign hit_vec[g]   = valid_vec[g] &&
                          (cur_word[g][WORD_W-1 -: TAG_W] == s1_tag);
  end

  // Hit encoding
  logic             hit;
  logic [WAY_W-1:0] hit_way;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && hit_vec[i]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(i);
      end
    end
  end

  // Victim and replacement state
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] acc_way;
  logic [WAYS-1:0]  ref_next;

  tdir_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .victim    (victim)
  );

  assign acc_way = hit ? hit_way : victim;

  tdir_ref_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_ref (
    .ref_in   (ref_vec),
    .used_way (acc_way),
    .ref_out  (ref_next)
  );

  logic [WORD_W-1:0] vic_word;
  logic              vic_dirty_valid;

  assign vic_word        = cur_word[victim];
  assign vic_dirty_valid = vic_word[F_VHI] && vic_word[F_VLO] && vic_word[F_DIRTY];

  // Updated entries for the whole set
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      new_word[i]        = cur_word[i];
      new_word[i][F_REF] = ref_next[i];
      if (acc_way == WAY_W'(i)) begin
        if (hit) begin
          if (s1_op == OP_STORE) new_word[i][F_DIRTY] = 1'b1;
        end else begin
          new_word[i][WORD_W-1 -: TAG_W] = s1_tag;
          new_word[i][F_VHI]             = 1'b1;
          new_word[i][F_VLO]             = 1'b1;
          new_word[i][F_DIRTY]           = (s1_op == OP_STORE);
        end
      end
    end
  end

  // Pipeline and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      s1_fwd     <= 1'b0;
      s1_op      <= OP_LOAD;
      s1_set     <= '0;
      s1_tag     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      wb_req     <= 1'b0;
      wb_addr    <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_op  <= req_store ? OP_STORE : OP_LOAD;
        s1_set <= req_set;
        s1_tag <= req_tag;
        s1_fwd <= s1_vld && (s1_set == req_set);
      end
      resp_valid <= s1_vld;
      resp_hit   <= s1_vld && hit;
      resp_way   <= acc_way;
      wb_req     <= s1_vld && !hit && vic_dirty_valid;
      wb_addr    <= {vic_word[WORD_W-1 -: TAG_W], s1_set, {OFFSET_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < WAYS; i++) fwd_word[i] <= new_word[i];
    end
  end

endmodule

// File: rtl/tdir_checker.sv
module tdir_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              wb_req,
  input logic [ADDR_W-1:0] wb_addr
);

  assert_accept_resp_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> ##1 resp_valid);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && ready) |=> ##1 !resp_valid);

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_wb_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (resp_valid && !resp_hit));

  assert_wb_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (wb_addr[OFFSET_W-1:0] == '0));

  assert_hit_has_resp_R4: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);

endmodule

bind wb_tag_directory tdir_checker #(
  .ADDR_W   (ADDR_W),
  .OFFSET_W (OFFSET_W)
) u_tdir_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .ready      (ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .wb_req     (wb_req),
  .wb_addr    (wb_addr)
);

// File: tb/wb_tag_directory_bench.sv
module wb_tag_directory_bench;

  localparam int SETS = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [31:0] req_addr  = '0;
  logic        ready;
  logic        resp_valid;
  logic        resp_hit;
  logic [1:0]  resp_way;
  logic        wb_req;
  logic [31:0] wb_addr;

  always #5 clk = ~clk;

  wb_tag_directory u_wb_tag_directory (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_addr   (req_addr),
    .ready      (ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_way   (resp_way),
    .wb_req     (wb_req),
    .wb_addr    (wb_addr)
  );

  typedef struct packed {
    logic [3:0][15:0] tg;
    logic [3:0]       v;
    logic [3:0]       d;
    logic [3:0]       r;
  } set_t;

  typedef struct packed {
    logic        vld;
    logic        hit;
    logic [1:0]  way;
    logic        wb;
    logic [31:0] wba;
  } exp_t;

  set_t  mdl [int];
  exp_t  e1, e2;
  string l1, l2;
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  int    prev_set = -1;

  function automatic logic [31:0] mk(input logic [15:0] tag, input int set, input int off);
    return {tag, 11'(set), 5'(off)};
  endfunction

  task automatic model(input logic st, input logic [31:0] a, output exp_t e);
    int    set;
    set_t  s;
    int    w;
    logic  h;
    logic [3:0] oh;
    set = int'(a[15:5]);
    s = mdl.exists(set) ? mdl[set] : '0;
    h = 1'b0; w = 0;
    for (int i = 0; i < 4; i++)
      if (!h && s.v[i] && s.tg[i] == a[31:16]) begin h = 1'b1; w = i; end
    if (!h) begin
      bit f = 0;
      for (int i = 0; i < 4; i++) if (!f && !s.v[i]) begin f = 1; w = i; end
      for (int i = 0; i < 4; i++) if (!f && !s.r[i]) begin f = 1; w = i; end
    end
    e.vld = 1'b1;
    e.hit = h;
    e.way = 2'(w);
    e.wb  = !h && s.v[w] && s.d[w];
    e.wba = {s.tg[w], a[15:5], 5'b0};
    oh = 4'b1 << w;
    s.r = s.r | oh;
    if (&s.r) s.r = oh;
    if (h) begin
      if (st) s.d[w] = 1'b1;
    end else begin
      s.tg[w] = a[31:16];
      s.v[w]  = 1'b1;
      s.d[w]  = st;
    end
    mdl[set] = s;
  endtask

  task automatic check_out();
    bit bad;
    n_checks++;
    if (!e2.vld) begin
      bad = resp_valid;
      if (bad) begin
        n_fail++;
        $display("FAIL %s idle: resp_valid=%0b expected 0", l2, resp_valid);
      end
    end else begin
      bad = !resp_valid || resp_hit != e2.hit || resp_way != e2.way ||
            wb_req != e2.wb || (e2.wb && wb_addr != e2.wba);
      if (bad) begin
        n_fail++;
        $display("FAIL %s: vld=%0b hit=%0b way=%0d wb=%0b wba=%h expected vld=1 hit=%0b way=%0d wb=%0b wba=%h",
                 l2, resp_valid, resp_hit, resp_way, wb_req, wb_addr,
                 e2.hit, e2.way, e2.wb, e2.wba);
      end
    end
  endtask

  // One clock: check the response due now, shift, then drive the next request
  task automatic step(input logic v, input logic st, input logic [31:0] a, input string lbl);
    exp_t en;
    @(negedge clk);
    check_out();
    e2 = e1; l2 = l1;
    en = '0;
    if (v) model(st, a, en);
    e1 = en; l1 = lbl;
    req_valid = v;
    req_store = st;
    req_addr  = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, "R3");
  endtask

  function automatic string rlabel(input exp_t e, input logic bb);
    if (bb) return "R9";
    if (e.hit) return "R4";
    if (e.wb) return "R8";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    int sets [6];
    e1 = '0; e2 = '0; l1 = "R3"; l2 = "R3";
    sets = '{0, 1, 2047, 7, 9, 100};
    void'($urandom(32'd20240611));

    // Reset state: R2
    repeat (3) @(negedge clk);
    n_checks++;
    if (ready !== 1'b0 || resp_valid !== 1'b0 || wb_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 reset: ready=%0b resp_valid=%0b wb_req=%0b expected 0 0 0",
               ready, resp_valid, wb_req);
    end
    rst = 1'b0;
    cnt = 0;
    while (ready !== 1'b1 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (resp_valid) begin
        n_checks++; n_fail++;
        $display("FAIL R2 sweep: resp_valid=1 expected 0");
      end
    end
    n_checks++;
    if (cnt != SETS) begin
      n_fail++;
      $display("FAIL R2 sweep length: actual=%0d expected=%0d", cnt, SETS);
    end

    // R1: offset ignored, back-to-back same set (R9)
    step(1, 0, mk(16'h1234, 7, 0),  "R5");
    step(1, 0, mk(16'h1234, 7, 31), "R1");
    step(1, 0, mk(16'h1234, 8, 4),  "R1");
    idle(2);
    // R5/R6: fill the set, then NRU victim
    step(1, 0, mk(16'h0001, 7, 0), "R5");
    step(1, 0, mk(16'h0002, 7, 0), "R5");
    step(1, 0, mk(16'h0003, 7, 0), "R5");
    idle(1);
    step(1, 0, mk(16'h0009, 7, 0), "R6");
    // R7 store hit marks dirty, R8 write-back on its eviction
    step(1, 1, mk(16'h0002, 7, 3), "R7");
    step(1, 0, mk(16'h000A, 7, 0), "R6");
    step(1, 0, mk(16'h000B, 7, 0), "R6");
    step(1, 0, mk(16'h000C, 7, 0), "R8");
    idle(2);
    // R7 store miss installs modified
    step(1, 1, mk(16'h0020, 9, 0), "R7");
    step(1, 0, mk(16'h0021, 9, 0), "R5");
    step(1, 0, mk(16'h0022, 9, 0), "R5");
    step(1, 0, mk(16'h0023, 9, 0), "R5");
    step(1, 0, mk(16'h0024, 9, 0), "R7");
    step(1, 0, mk(16'h0024, 9, 8), "R4");
    idle(2);

    // Random mix over a small pool of sets and tags
    prev_set = -1;
    for (int k = 0; k < 6000; k++) begin
      logic        v, st;
      logic [15:0] tg;
      int          s;
      logic [31:0] a;
      exp_t        pe;
      set_t        snap;
      v  = ($urandom % 100) < 80;
      st = ($urandom % 100) < 40;
      s  = sets[$urandom % 6];
      tg = (($urandom % 10) == 0) ? 16'($urandom) : 16'($urandom % 6);
      a  = mk(tg, s, int'($urandom % 32));
      if (v) begin
        snap = mdl.exists(s) ? mdl[s] : '0;
        mdl[s] = snap;
        pe = '0;
        // label from a look-ahead on a copy of the model state
        model(st, a, pe);
        mdl[s] = snap;
        step(1, st, a, rlabel(pe, prev_set == s));
        prev_set = s;
      end else begin
        step(0, 0, 32'h0, "R3");
        prev_set = -1;
      end
    end
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule